// File: doc/BRIEF.md
# Multichannel tagged word serializer

This block takes one time-aligned set of four 32-bit channel samples and sends it out as four 64-bit words on one output stream. The output stream can take only one word per clock, so each set is spread over four beats. The sample sits in the low half of every word. The high half is a tag: the channel index, plus a sequence number that all four words of a set share. A consumer downstream of a narrow transport can use the tag to put sets back together and to detect words that have gone missing or do not match.

The input is a whole set with a valid/ready handshake. The output is a 64-bit valid/ready stream. A start-enable input gates the block. The producer raises it only after the consumer side is ready to take words. While start-enable is low, no new set is accepted. The sequence count starts again at zero for each run.

Top module: `tagged_word_serializer`

## Requirements
- R1: Bits [31:0] of every output word equal the sample of the channel that the word carries, with no change.
- R2: Bits [33:32] hold the channel index. The words of a set leave in index order 0, 1, 2, 3, and channel g takes bits [32g+31:32g] of `set_data`.
- R3: All words of one set carry the same sequence number in the top SEQ_W bits (bits [63:48] at the default of 16). Every bit between the index field and the sequence field is zero.
- R4: The first set accepted after start-enable rises carries sequence 0. Each completed set adds one, and the count wraps modulo 2^SEQ_W.
- R5: The block emits at most one word per clock. Every accepted set produces exactly four output words, the first of them valid in the cycle after the set is accepted.
- R6: `set_ready` is high only while start-enable is high and no word of the previous set is still pending. It rises in the cycle after the last word is accepted.
- R7: While `word_valid` is high and `word_ready` is low, the word stays valid and unchanged in the next cycle. No word is skipped or sent twice.
- R8: If start-enable drops while a set is in flight, the remaining words of that set are still delivered, and no further set is accepted.
- R9: After reset, `word_valid` is low, and `set_ready` is low while start-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start-enable; gates acceptance of new sets |
| set_valid | input | 1 | A sample set is offered |
| set_ready | output | 1 | The block can take a set this cycle |
| set_data | input | NUM_CH*SAMPLE_W (128) | Channel samples, channel g in bits [32g+31:32g] |
| word_valid | output | 1 | An output word is present |
| word_ready | input | 1 | The consumer takes the word this cycle |
| word_data | output | WORD_W (64) | Tagged output word |

## Verification
The bench stalls the output at random and mid-set. A design that advanced the channel without a handshake would skip a word, and one that failed to hold the word would send a changed or doubled one. It runs past the wrap of a narrowed sequence field, which catches a counter that saturates or has the wrong width. It also drops start-enable while a set is in flight and then raises it again: this exposes a design that truncates the set, accepts a new set while disabled, or carries the old count into the next run. It offers a set while disabled and one in the cycle a set finishes, which catches a ready signal raised too early or left ungated.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;

endpackage

// File: rtl/tws_set_buffer.sv
module tws_set_buffer
    import tws_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 32,
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SET_W   = NUM_CH * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SET_W-1:0]    set_data,
    input  logic                advance,
    output logic                busy,
    output logic                last,
    output logic [IDX_W-1:0]    ch_idx,
    output logic [SAMPLE_W-1:0] sample
);

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   ch;
        logic [SET_W-1:0]   samples;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [SAMPLE_W-1:0] lane [NUM_CH];

    // split the held set into per-channel lanes
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign lane[g] = buf_q.samples[g*SAMPLE_W +: SAMPLE_W];
    end

    assign busy   = (buf_q.phase == PH_EMIT);
    assign last   = (buf_q.ch == IDX_W'(NUM_CH - 1));
    assign ch_idx = buf_q.ch;
    assign sample = lane[buf_q.ch];

    always_comb begin
        buf_d = buf_q;
        if (buf_q.phase == PH_IDLE) begin
            if (load) begin
                buf_d.phase   = PH_EMIT;
                buf_d.ch      = '0;
                buf_d.samples = set_data;
            end
        end else if (advance) begin
            if (last) begin
                buf_d.phase = PH_IDLE;
                buf_d.ch    = '0;
            end else begin
                buf_d.ch = buf_q.ch + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q.phase   <= PH_IDLE;
            buf_q.ch      <= '0;
            buf_q.samples <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

endmodule

// File: rtl/tws_seq_counter.sv
module tws_seq_counter #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    output logic [SEQ_W-1:0] seq
);

    typedef struct packed {
        logic [SEQ_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    assign seq = seq_q.cnt;

    always_comb begin
        seq_d = seq_q;
        if (clr) begin
            seq_d.cnt = '0;
        end else if (bump) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/tws_word_packer.sv
module tws_word_packer #(
    parameter int SAMPLE_W = 32,
    parameter int IDX_W    = 2,
    parameter int SEQ_W    = 16,
    parameter int WORD_W   = 64,
    localparam int ZERO_W  = WORD_W - SEQ_W - IDX_W - SAMPLE_W
) (
    input  logic [SEQ_W-1:0]    seq,
    input  logic [IDX_W-1:0]    ch_idx,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [WORD_W-1:0]   word
);

    if (ZERO_W > 0) begin : g_pad
        assign word = {seq, {ZERO_W{1'b0}}, ch_idx, sample};
    end else begin : g_tight
        assign word = {seq, ch_idx, sample};
    end

endmodule

// File: rtl/tagged_word_serializer.sv
module tagged_word_serializer #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 32,
    parameter int SEQ_W    = 16,
    parameter int WORD_W   = 64,
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SET_W   = NUM_CH * SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              set_valid,
    output logic              set_ready,
    input  logic [SET_W-1:0]  set_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data
);

    logic                busy;
    logic                last;
    logic [IDX_W-1:0]    ch_idx;
    logic [SAMPLE_W-1:0] sample;
    logic [SEQ_W-1:0]    seq;
    logic                load;
    logic                advance;

    assign set_ready  = run_en & ~busy;
    assign load       = set_valid & set_ready;
    assign word_valid = busy;
    assign advance    = word_valid & word_ready;

    tws_set_buffer #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .set_data (set_data),
        .advance  (advance),
        .busy     (busy),
        .last     (last),
        .ch_idx   (ch_idx),
        .sample   (sample)
    );

    tws_seq_counter #(
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~run_en & ~busy),
        .bump  (advance & last),
        .seq   (seq)
    );

    tws_word_packer #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W),
        .SEQ_W    (SEQ_W),
        .WORD_W   (WORD_W)
    ) u_pack (
        .seq    (seq),
        .ch_idx (ch_idx),
        .sample (sample),
        .word   (word_data)
    );

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 32,
    parameter int SEQ_W    = 16,
    parameter int WORD_W   = 64,
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              set_valid,
    input logic              set_ready,
    input logic              word_valid,
    input logic              word_ready,
    input logic [WORD_W-1:0] word_data
);

    logic [IDX_W-1:0] idx_f;
    logic [SEQ_W-1:0] seq_f;
    logic             hs;
    logic             hs_mid;

    assign idx_f  = word_data[SAMPLE_W +: IDX_W];
    assign seq_f  = word_data[WORD_W-1 -: SEQ_W];
    assign hs     = word_valid & word_ready;
    assign hs_mid = hs & (idx_f != IDX_W'(NUM_CH - 1));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid && $stable(word_data));

    // R6
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ready |-> run_en && !word_valid);

    // R2
    ch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mid |=> word_valid && idx_f == IDX_W'($past(idx_f) + 1'b1));

    // R3
    seq_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mid |=> seq_f == $past(seq_f));

    // R5
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid && set_ready |=> word_valid && idx_f == '0);

    // R8
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en && !word_valid |=> !word_valid);

endmodule

bind tagged_word_serializer tws_checker #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .SEQ_W    (SEQ_W),
    .WORD_W   (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .set_valid  (set_valid),
    .set_ready  (set_ready),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data)
);

// File: tb/sim_tagged_word_serializer.sv
`timescale 1ns/1ps
module sim_tagged_word_serializer;

    localparam int NCH   = 4;
    localparam int SW    = 32;
    localparam int QW    = 6;
    localparam int WW    = 64;
    localparam int ZW    = WW - QW - 2 - SW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run_en = 1'b0;
    logic            set_valid = 1'b0;
    logic            set_ready;
    logic [NCH*SW-1:0] set_data = '0;
    logic            word_valid;
    logic            word_ready = 1'b0;
    logic [WW-1:0]   word_data;

    int vectors = 0;
    int misses = 0;
    int ready_mode = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [WW-1:0] exp_q[$];
    int            mseq = 0;
    bit            prev_stall = 0;
    logic [WW-1:0] prev_word = '0;

    always #2 clk = ~clk;

    tagged_word_serializer #(
        .NUM_CH(NCH), .SAMPLE_W(SW), .SEQ_W(QW), .WORD_W(WW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .set_valid(set_valid), .set_ready(set_ready), .set_data(set_data),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data)
    );

    task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                         input logic [WW-1:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NCH*SW-1:0] make_set(input int n);
        logic [NCH*SW-1:0] d;
        for (int g = 0; g < NCH; g++)
            d[g*SW +: SW] = {8'(n), 8'(g), 16'hBEEF ^ 16'(n * 37)};
        return d;
    endfunction

    // output-ready pattern driver
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0: word_ready <= 1'b1;
            1: word_ready <= lfsr[3] | lfsr[7];
            default: word_ready <= 1'b0;
        endcase
    end

    // reference model, checked between edges and advanced for the coming edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic exp_v;
            logic exp_r;
            logic [WW-1:0] e;
            bit empty_now;
            exp_v = (exp_q.size() != 0);
            exp_r = run_en && (exp_q.size() == 0);
            check(word_valid == exp_v, "R5 word_valid", WW'(word_valid), WW'(exp_v));
            if (!run_en)
                check(set_ready == 1'b0, "R8 set_ready while disabled", WW'(set_ready), 0);
            else
                check(set_ready == exp_r, "R6 set_ready", WW'(set_ready), WW'(exp_r));
            if (word_valid && exp_v) begin
                e = exp_q[0];
                check(word_data[SW-1:0] == e[SW-1:0], "R1 sample", word_data, e);
                check(word_data[SW +: 2] == e[SW +: 2], "R2 channel index", word_data, e);
                check(word_data[SW+2 +: ZW] == '0, "R3 zero field", word_data, e);
                check(word_data[WW-1 -: QW] == e[WW-1 -: QW], "R4 sequence", word_data, e);
            end
            if (prev_stall)
                check(word_valid && word_data == prev_word, "R7 hold on stall",
                      word_data, prev_word);
            prev_stall = word_valid && !word_ready;
            prev_word  = word_data;
            // advance the model
            empty_now = (exp_q.size() == 0);
            if (!run_en && empty_now) mseq = 0;
            if (word_valid && word_ready && !empty_now) begin
                e = exp_q.pop_front();
                if (e[SW +: 2] == 2'(NCH - 1)) mseq = (mseq + 1) % (1 << QW);
            end
            if (set_valid && set_ready) begin
                for (int g = 0; g < NCH; g++)
                    exp_q.push_back({QW'(mseq), {ZW{1'b0}}, 2'(g), set_data[g*SW +: SW]});
            end
        end else begin
            exp_q.delete();
            mseq = 0;
            prev_stall = 0;
        end
    end

    task automatic send_set(input int n);
        @(negedge clk);
        set_valid = 1'b1;
        set_data  = make_set(n);
        do @(posedge clk); while (!set_ready);
    endtask

    task automatic idle_in(input int cyc);
        @(negedge clk);
        set_valid = 1'b0;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check(word_valid == 1'b0, "R9 word_valid after reset", WW'(word_valid), 0);
        check(set_ready == 1'b0, "R9 set_ready after reset", WW'(set_ready), 0);

        // offered set while disabled must not be taken (R6, R8)
        @(negedge clk);
        set_valid = 1'b1;
        set_data  = make_set(99);
        repeat (8) @(negedge clk);
        set_valid = 1'b0;

        // enable, back-to-back sets across the sequence wrap (R4, R5)
        run_en = 1'b1;
        ready_mode = 0;
        for (int n = 0; n < 70; n++) send_set(n);
        idle_in(8);

        // random output stalls (R7)
        ready_mode = 1;
        for (int n = 0; n < 30; n++) send_set(100 + n);
        idle_in(30);

        // drop enable mid-set while stalled (R8), then restart at sequence 0 (R4)
        ready_mode = 2;
        send_set(200);
        @(negedge clk);
        run_en = 1'b0;
        set_data = make_set(201);
        repeat (4) @(negedge clk);
        ready_mode = 0;
        repeat (12) @(negedge clk);
        set_valid = 1'b0;
        run_en = 1'b1;
        for (int n = 0; n < 3; n++) send_set(300 + n);
        idle_in(10);
        check(exp_q.size() == 0, "R5 all words delivered", WW'(exp_q.size()), 0);
        finish_run();
    end

endmodule